// File: doc/BRIEF.md
# Power Controller Mode Sequencer

This block is the digital mode sequencer of a dual-channel bidirectional power converter controller. It takes comparator flags that are already digital and synchronous to the clock: the bias-pin comparators at three thresholds, the good flags of the primary and logic supplies, two shutdown-pin comparators (a valid level and a trip level), and for each channel an enable, a direction-valid flag and a soft-start-above-threshold flag. From these it selects one operating mode and drives the enables that go to the analog blocks: logic reset, LDO driver, oscillator, a soft-start release and a gate-drive permit for each channel, and a soft-start clamp.

An emergency stop is latched. A low on the shutdown pin's trip comparator that lasts a qualified number of clock cycles while the converter runs forces the latched mode. Only a qualified low on the bias pin clears it. Both windows are cycle counters whose lengths come from the clock frequency and the window durations (2.5 µs and 10 µs at the defaults). Each channel has its own release and permit path, so either channel can deliver power on its own, or both can.

All outputs are registered. A change on any input shows at the outputs after the next rising clock edge. Every port is a plain control or status level, with no streaming handshake.

Top module: `pwr_mode_seq`

## Requirements
- R1: While not latched, a low `bias_gt_off` selects mode code 0 (shutdown) at the next edge. In code 0, `logic_rst` is 1 and `ldo_en`, `osc_en`, `ss_release`, `gate_permit` and `ss_clamp` are all 0. Reset also leaves code 0.
- R2: With `bias_gt_off`, `bias_gt_init` and `sd_valid` high and the run conditions not met, the mode is code 1 (initialization). `ldo_en` is 1 and `osc_en` is 0.
- R3: With `bias_gt_run`, `vcc_ok` and `vdd_ok` high and `sd_valid` high, the mode is code 2 (standby) when no channel requests power. `osc_en` and `ldo_en` are 1 and `gate_permit` is 0.
- R4: When the run conditions hold and channel i has `ch_en[i]` and `dir_ok[i]` high, `ss_release[i]` is 1 after the next edge and the mode is code 3 (delivering).
- R5: `gate_permit[i]` rises one edge after `ss_up[i]` is seen high while `ss_release[i]` is already 1. `ss_up[i]` has no effect on a channel that is not released.
- R6: A low `dir_ok[i]` on a released channel clears `ss_release[i]` and `gate_permit[i]` at the next edge.
- R7: In modes 2 or 3, a low on `sd_trip_n` for TRIP cycles in a row (2.5 µs of clock) selects code 4 (latched) on the TRIP-th edge. A shorter low restarts the count. In code 4, `gate_permit` and `ss_release` are 0, `ss_clamp` is 1, `ldo_en` is 1 and `osc_en` is 0.
- R8: Code 4 is held whatever the other inputs do. It leaves only to code 0, after `bias_gt_off` has been low for CLR cycles in a row (10 µs of clock). A shorter low restarts that count.
- R9: The two channels are independent: the release and permit of one channel do not depend on the enable, direction or soft-start flags of the other.
- R10: Once the mode is 2 or 3, a low `sd_valid` alone does not leave those modes. It matters only for entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_gt_off | input | 1 | Bias pin above the shutdown threshold |
| bias_gt_init | input | 1 | Bias pin above the initialization threshold |
| bias_gt_run | input | 1 | Bias pin above the run threshold |
| vcc_ok | input | 1 | Primary supply good |
| vdd_ok | input | 1 | Logic supply good |
| sd_valid | input | 1 | Shutdown pin above its valid level |
| sd_trip_n | input | 1 | Shutdown pin above its trip level (low = trip request) |
| ch_en | input | 2 | Per-channel enable |
| dir_ok | input | 2 | Per-channel direction input clearly high or low |
| ss_up | input | 2 | Per-channel soft-start above its switching threshold |
| mode | output | 3 | 0 shutdown, 1 init, 2 standby, 3 delivering, 4 latched |
| logic_rst | output | 1 | Internal logic reset |
| ldo_en | output | 1 | LDO driver enable |
| osc_en | output | 1 | Oscillator enable |
| ss_release | output | 2 | Per-channel soft-start release |
| gate_permit | output | 2 | Per-channel gate-drive permit |
| ss_clamp | output | 1 | Clamp both soft-start nodes low |

## Verification
The hardest situations to reach are the two counter boundaries: a trip pulse exactly one cycle short of the window, then one that is exactly long enough, and the same pair for the bias-low clear window while latched. The stimulus drives these lows for a counted number of falling edges and then releases them. It reaches latched mode from a delivering state with both channels permitted, so the clamp and the withdrawal of the permits are observed together. A behavioural reference model in the bench tracks every output on every cycle through these sequences.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    M_OFF   = 3'd0,
    M_INIT  = 3'd1,
    M_STBY  = 3'd2,
    M_RUN   = 3'd3,
    M_LATCH = 3'd4
  } mode_e;

  function automatic int unsigned cycles_for_ns(int unsigned clk_hz, int unsigned ns);
    longint unsigned prod;
    prod = longint'(clk_hz) * longint'(ns);
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/pms_qualify.sv
module pms_qualify #(
  parameter int unsigned LIMIT = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic done
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!arm)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = arm && (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R7
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> cnt == '0); // R8
endmodule

// File: rtl/pms_channel.sv
module pms_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic run_next,
  input  logic en,
  input  logic dir_ok,
  input  logic ss_up,
  output logic release_q,
  output logic permit_q
);
  logic rel_d, perm_d;

  always_comb begin
    rel_d  = run_next && en && dir_ok;
    perm_d = rel_d && release_q && ss_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q <= 1'b0;
      permit_q  <= 1'b0;
    end else begin
      release_q <= rel_d;
      permit_q  <= perm_d;
    end
  end

  AST_PERMIT_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    permit_q |-> release_q); // R5
  AST_DIR_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_ok |=> !release_q && !permit_q); // R6
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TRIP_NS = 2500,
  parameter int unsigned CLR_NS  = 10000,
  parameter int unsigned N_CH    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bias_gt_off,
  input  logic            bias_gt_init,
  input  logic            bias_gt_run,
  input  logic            vcc_ok,
  input  logic            vdd_ok,
  input  logic            sd_valid,
  input  logic            sd_trip_n,
  input  logic [N_CH-1:0] ch_en,
  input  logic [N_CH-1:0] dir_ok,
  input  logic [N_CH-1:0] ss_up,
  output logic [2:0]      mode,
  output logic            logic_rst,
  output logic            ldo_en,
  output logic            osc_en,
  output logic [N_CH-1:0] ss_release,
  output logic [N_CH-1:0] gate_permit,
  output logic            ss_clamp
);
  localparam int unsigned TRIP_CYC = cycles_for_ns(CLK_HZ, TRIP_NS);
  localparam int unsigned CLR_CYC  = cycles_for_ns(CLK_HZ, CLR_NS);

  mode_e mode_q, mode_d;
  logic  operating, run_ok, any_req, trip_done, clr_done, run_next;

  always_comb begin
    operating = (mode_q == M_STBY) || (mode_q == M_RUN);
    run_ok    = bias_gt_run && vcc_ok && vdd_ok && (sd_valid || operating);
    any_req   = |(ch_en & dir_ok);
  end

  pms_qualify #(.LIMIT(TRIP_CYC)) u_trip (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (operating && !sd_trip_n),
    .done (trip_done)
  );

  pms_qualify #(.LIMIT(CLR_CYC)) u_clear (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  ((mode_q == M_LATCH) && !bias_gt_off),
    .done (clr_done)
  );

  always_comb begin
    if (mode_q == M_LATCH)              mode_d = clr_done ? M_OFF : M_LATCH;
    else if (!bias_gt_off)              mode_d = M_OFF;
    else if (trip_done)                 mode_d = M_LATCH;
    else if (run_ok)                    mode_d = any_req ? M_RUN : M_STBY;
    else if (bias_gt_init && sd_valid)  mode_d = M_INIT;
    else                                mode_d = M_OFF;
    run_next = (mode_d == M_STBY) || (mode_d == M_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_OFF;
    else        mode_q <= mode_d;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    pms_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_next (run_next),
      .en       (ch_en[i]),
      .dir_ok   (dir_ok[i]),
      .ss_up    (ss_up[i]),
      .release_q(ss_release[i]),
      .permit_q (gate_permit[i])
    );
  end

  assign mode      = mode_q;
  assign logic_rst = (mode_q == M_OFF);
  assign ldo_en    = (mode_q != M_OFF);
  assign osc_en    = operating;
  assign ss_clamp  = (mode_q == M_LATCH);

  AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == M_OFF |-> ss_release == '0 && gate_permit == '0); // R1
  AST_LATCH_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == M_LATCH |-> gate_permit == '0 && ss_release == '0); // R7
  AST_LATCH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == M_LATCH |=> mode_q == M_LATCH || mode_q == M_OFF); // R8
  AST_PERMIT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    gate_permit != '0 |-> osc_en); // R3
  AST_RELEASE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ss_release != '0 |-> mode_q == M_RUN); // R4
endmodule

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;
  localparam int TRIP = 250;   // 2.5 us at 100 MHz
  localparam int CLR  = 1000;  // 10 us at 100 MHz

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, b_off, b_init, b_run, vcc, vdd, sdv, sdt;
  logic [1:0] en, dir, ssu;
  logic [2:0] mode;
  logic lrst, ldo, osc, clamp;
  logic [1:0] rel, perm;

  pwr_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .bias_gt_off(b_off), .bias_gt_init(b_init),
    .bias_gt_run(b_run), .vcc_ok(vcc), .vdd_ok(vdd), .sd_valid(sdv),
    .sd_trip_n(sdt), .ch_en(en), .dir_ok(dir), .ss_up(ssu), .mode(mode),
    .logic_rst(lrst), .ldo_en(ldo), .osc_en(osc), .ss_release(rel),
    .gate_permit(perm), .ss_clamp(clamp)
  );

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  // behavioural reference model
  int m_mode, m_trip, m_clr, nm;
  bit [1:0] m_rel, m_perm, nrel;
  bit oper;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_trip = 0; m_clr = 0; m_rel = 0; m_perm = 0;
    end else begin
      oper = (m_mode == 2 || m_mode == 3);
      if (oper && !sdt) m_trip++; else m_trip = 0;
      if (m_mode == 4 && !b_off) m_clr++; else m_clr = 0;
      if (m_mode == 4) nm = (m_clr >= CLR) ? 0 : 4;
      else if (!b_off) nm = 0;
      else if (m_trip >= TRIP) nm = 4;
      else if (b_run && vcc && vdd && (sdv || oper)) nm = ((en & dir) != 0) ? 3 : 2;
      else if (b_init && sdv) nm = 1;
      else nm = 0;
      if (nm != m_mode) begin m_trip = 0; m_clr = 0; end
      for (int i = 0; i < 2; i++) begin
        nrel[i] = (nm == 2 || nm == 3) && en[i] && dir[i];
        m_perm[i] = nrel[i] && m_rel[i] && ssu[i];
      end
      m_rel = nrel;
      m_mode = nm;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R10 mode", mode, m_mode);
    chk("R1 logic_rst", lrst, m_mode == 0);
    chk("R2 ldo_en", ldo, m_mode != 0);
    chk("R3 osc_en", osc, m_mode == 2 || m_mode == 3);
    chk("R7 ss_clamp", clamp, m_mode == 4);
    chk("R4 ss_release", rel, m_rel);
    chk("R5 gate_permit", perm, m_perm);
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp_all();
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; b_off = 0; b_init = 0; b_run = 0; vcc = 0; vdd = 0;
    sdv = 0; sdt = 1; en = 0; dir = 0; ssu = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset logic_rst", lrst, 1);
    rst_n = 1;
    step(3);
    chk("R1 idle shutdown", mode, 0);
    // R2 initialization
    b_off = 1; b_init = 1; sdv = 1;
    step(1);
    chk("R2 init mode", mode, 1);
    chk("R2 ldo on", ldo, 1);
    chk("R2 osc off", osc, 0);
    // R3 standby
    b_run = 1; vcc = 1; step(2);
    chk("R3 needs vdd", mode, 1);
    vdd = 1; ssu = 2'b10; step(1);
    chk("R3 standby", mode, 2);
    chk("R3 osc on", osc, 1);
    chk("R3 no gates", perm, 0);
    // R4 channel 0 delivering; R5 ss_up on unreleased ch1 ignored
    en = 2'b01; dir = 2'b01; step(1);
    chk("R4 deliver", mode, 3);
    chk("R4 release0", rel, 2'b01);
    step(2);
    chk("R5 ch1 unreleased no permit", perm, 0);
    ssu = 2'b11; step(1);
    chk("R5 permit0", perm, 2'b01);
    // R9 second channel independent
    en = 2'b11; dir = 2'b11; step(1);
    chk("R9 both released", rel, 2'b11);
    chk("R9 ch1 permit waits", perm, 2'b01);
    step(1);
    chk("R9 both permitted", perm, 2'b11);
    // R6 direction invalid on ch0
    dir = 2'b10; step(1);
    chk("R6 ch0 withdrawn", rel, 2'b10);
    chk("R6 ch0 permit low", perm, 2'b10);
    chk("R9 ch1 kept", mode, 3);
    dir = 2'b11; step(3);
    // R10 sd_valid loss while running
    sdv = 0; step(4);
    chk("R10 still delivering", mode, 3);
    sdv = 1;
    // R7 short trip pulse
    sdt = 0; step(TRIP - 1);
    sdt = 1; step(1);
    chk("R7 short pulse no latch", mode, 3);
    sdt = 0; step(TRIP - 1);
    chk("R7 not yet", mode, 3);
    step(1);
    chk("R7 latched", mode, 4);
    chk("R7 clamp", clamp, 1);
    chk("R7 gates low", perm, 0);
    sdt = 1; step(5);
    // R8 latched holds
    b_run = 0; vcc = 0; en = 0; step(3);
    chk("R8 hold", mode, 4);
    b_run = 1; vcc = 1; en = 2'b11;
    b_off = 0; step(CLR - 1);
    b_off = 1; step(2);
    chk("R8 short clear ignored", mode, 4);
    b_off = 0; step(CLR - 1);
    chk("R8 not yet clear", mode, 4);
    step(1);
    chk("R8 cleared to shutdown", mode, 0);
    // re-enter and drop bias during delivery
    b_off = 1; step(2);
    chk("R4 re-deliver", mode, 3);
    b_off = 0; step(1);
    chk("R1 bias drop", mode, 0);
    chk("R1 no release", rel, 0);
    step(2);
    finish_run();
  end
endmodule